// File: doc/BRIEF.md
# Streaming Configuration Host

This block drives a parallel streaming configuration link from the host end. A local source hands it bytes one at a time over a valid/ready pair. The block gathers them into words of 8, 16 or 32 bits, with the earliest byte in the lowest lane. It then offers each word to the target under the target's ready signal. Ready comes from another clock domain, so it passes through a two-flop synchronizer. A small word queue sits between the packer and the link, so the byte source keeps moving while the host's view of ready lags.

The block also runs the active-low handshake that opens a configuration. On a start request it waits until the status line from the target is high. It then pulls the request line low and waits for status to follow low. It releases the request line and waits for status to return high. Only then does it begin streaming. The request line only ever changes while it agrees with the synchronized status line. While the request line is low, a rewind output tells the byte source to restart from the first byte of its image.

During streaming, a low on the status line ends the attempt with an error. A high on the completion input ends it with done. In both cases the host drops every partial word and queued word and returns to idle. The next start request runs the whole sequence again.

Top module: `cfg_stream_host`

## Requirements
- R1: After reset the request output `cfg_ncfg` is high, and `cfg_valid`, `in_ready`, `src_rewind`, `done` and `err` are all low.
- R2: `cfg_ncfg` changes only in a cycle where its previous value equals the synchronized `cfg_nstatus`. After a `start` pulse it stays high for as long as `cfg_nstatus` is held low. Once status is high, it goes low until status follows low, then returns high. Streaming (`in_ready` high) begins when status is high again.
- R3: Bytes are packed lowest lane first. The first byte accepted after streaming begins lands in `cfg_data[7:0]`, the next in `cfg_data[15:8]`, and so on. The word is complete when all BUS_W/8 lanes are filled.
- R4: `cfg_valid` is high only while streaming, only when `cfg_ready` was high at the clock edge two cycles earlier, and only when a complete word is queued. Every cycle with `cfg_valid` high transfers one word, and words leave in the order they were packed.
- R5: While `cfg_ready` toggles, no word is lost, duplicated or reordered.
- R6: The word queue holds SKID_DEPTH words. While it is full, `in_ready` is low. With `cfg_ready` held low from an empty queue, exactly SKID_DEPTH×BUS_W/8 bytes are accepted.
- R7: When synchronized `cfg_conf_done` is high during streaming, `done` goes high. `cfg_valid` and `in_ready` then stay low, and `cfg_ncfg` stays high.
- R8: When synchronized `cfg_nstatus` goes low during streaming, `err` goes high. The queue and any partial word are discarded, `cfg_valid` and `in_ready` go low, and `cfg_ncfg` stays high.
- R9: A `start` pulse in idle clears `done` and `err`. `src_rewind` is high while `cfg_ncfg` is low. The next stream begins at lane 0 with no bytes left over from the earlier attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration attempt (taken in idle only) |
| in_valid | input | 1 | Byte source has a byte |
| in_data | input | 8 | Byte from the source |
| in_ready | output | 1 | Host takes the byte this cycle when `in_valid` is high |
| cfg_data | output | BUS_W | Configuration word toward the target |
| cfg_valid | output | 1 | Word on `cfg_data` is being transferred |
| cfg_ready | input | 1 | Target can accept data (asynchronous) |
| cfg_ncfg | output | 1 | Active-low configuration request |
| cfg_nstatus | input | 1 | Active-low status from the target (asynchronous) |
| cfg_conf_done | input | 1 | Target has received the whole image (asynchronous) |
| src_rewind | output | 1 | Byte source must restart from the first byte |
| done | output | 1 | Last attempt completed |
| err | output | 1 | Last attempt failed on a status error |

## Verification
The bench builds the host with a 32-bit bus and a four-word queue. The four-lane width exercises every lane position and the byte-order rule on full words. The shallow queue lets a held-low ready fill it within a few cycles, so the back-pressure limit of sixteen bytes is reached directly. A target model echoes the request line back onto status after a delay and can force status low. This covers the blocked start, the normal handshake, a mid-stream error that leaves a partial word behind, and a clean restart after it.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ARM     = 3'd1,
    PH_PULSE   = 3'd2,
    PH_RELEASE = 3'd3,
    PH_STREAM  = 3'd4
  } phase_e;

endpackage

// File: rtl/cfg_host_sync.sv
module cfg_host_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/cfg_host_packer.sv
module cfg_host_packer #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             accept,
  input  logic [7:0]       byte_data,
  output logic             word_push,
  output logic [BUS_W-1:0] word_data
);

  localparam int BYTES = BUS_W / 8;
  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) : 1;

  generate
    if (BYTES == 1) begin : g_narrow
      assign word_push = accept;
      assign word_data = byte_data;
    end else begin : g_wide
      localparam logic [IDXW-1:0] LAST = IDXW'(BYTES - 1);

      logic [IDXW-1:0] idx_q, idx_d;
      logic [7:0]      lane_q [BYTES-1];

      always_comb begin
        idx_d = idx_q;
        if (flush) begin
          idx_d = '0;
        end else if (accept) begin
          idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
      end

      for (genvar g = 0; g < BYTES - 1; g++) begin : g_lane
        logic lane_en;
        assign lane_en = accept && !flush && (idx_q == IDXW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       lane_q[g] <= '0;
          else if (lane_en) lane_q[g] <= byte_data;
        end

        assign word_data[g*8 +: 8] = lane_q[g];
      end

      // the last lane is taken straight from the byte that completes the word
      assign word_data[BUS_W-1 -: 8] = byte_data;
      assign word_push = accept && !flush && (idx_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/cfg_host_fifo.sv
module cfg_host_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PTRW-1:0] PTR_LAST = PTRW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTRW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
  import cfg_host_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic nst_s,
  input  logic done_s,
  output logic ncfg,
  output logic streaming,
  output logic rewind,
  output logic done,
  output logic err
);

  phase_e state_q, state_d;
  logic   ncfg_q, ncfg_d;
  logic   done_q, done_d;
  logic   err_q, err_d;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    err_d   = err_q;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          done_d  = 1'b0;
          err_d   = 1'b0;
          state_d = PH_ARM;
        end
      end
      PH_ARM:     if (nst_s)  state_d = PH_PULSE;
      PH_PULSE:   if (!nst_s) state_d = PH_RELEASE;
      PH_RELEASE: if (nst_s)  state_d = PH_STREAM;
      PH_STREAM: begin
        if (!nst_s) begin
          err_d   = 1'b1;
          state_d = PH_IDLE;
        end else if (done_s) begin
          done_d  = 1'b1;
          state_d = PH_IDLE;
        end
      end
      default: state_d = PH_IDLE;
    endcase
    ncfg_d = (state_d != PH_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      ncfg_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ncfg_q  <= ncfg_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign ncfg      = ncfg_q;
  assign streaming = (state_q == PH_STREAM);
  assign rewind    = (state_q == PH_PULSE);
  assign done      = done_q;
  assign err       = err_q;

  // R2
  ncfg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncfg != $past(ncfg)) |-> ($past(ncfg) == $past(nst_s)));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !$past(nst_s));

  // R8
  err_ncfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ncfg);

endmodule

// File: rtl/cfg_stream_host.sv
module cfg_stream_host #(
  parameter int BUS_W      = 32,
  parameter int SKID_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [BUS_W-1:0] cfg_data,
  output logic             cfg_valid,
  input  logic             cfg_ready,
  output logic             cfg_ncfg,
  input  logic             cfg_nstatus,
  input  logic             cfg_conf_done,
  output logic             src_rewind,
  output logic             done,
  output logic             err
);

  generate
    if (!(BUS_W == 8 || BUS_W == 16 || BUS_W == 32)) begin : g_bad_width
      $error("BUS_W must be 8, 16 or 32");
    end
    if (SKID_DEPTH < 3) begin : g_bad_depth
      $error("SKID_DEPTH must be at least 3");
    end
  endgenerate

  logic [2:0]       sync_q;
  logic             rdy_s, nst_s, done_s;
  logic             streaming, flush;
  logic             accept, word_push, q_empty, q_full;
  logic [BUS_W-1:0] word_data;

  cfg_host_sync #(.WIDTH(3)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cfg_conf_done, cfg_nstatus, cfg_ready}),
    .q_sync  (sync_q)
  );

  assign rdy_s  = sync_q[0];
  assign nst_s  = sync_q[1];
  assign done_s = sync_q[2];

  cfg_host_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .nst_s     (nst_s),
    .done_s    (done_s),
    .ncfg      (cfg_ncfg),
    .streaming (streaming),
    .rewind    (src_rewind),
    .done      (done),
    .err       (err)
  );

  assign flush    = !streaming;
  assign in_ready = streaming && !q_full;
  assign accept   = in_valid && in_ready;

  cfg_host_packer #(.BUS_W(BUS_W)) pack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .accept    (accept),
    .byte_data (in_data),
    .word_push (word_push),
    .word_data (word_data)
  );

  assign cfg_valid = streaming && rdy_s && !q_empty;

  cfg_host_fifo #(.WIDTH(BUS_W), .DEPTH(SKID_DEPTH)) skid_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (word_push),
    .din   (word_data),
    .pop   (cfg_valid),
    .dout  (cfg_data),
    .empty (q_empty),
    .full  (q_full)
  );

  // R4
  valid_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(cfg_ready, 2));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cfg_valid && !in_ready && cfg_ncfg));

  // R9
  rewind_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rewind |-> (!cfg_ncfg && !in_ready));

endmodule

// File: tb/cfg_stream_host_tb_top.sv
module cfg_stream_host_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 32;
  localparam int DEPTH      = 4;
  localparam int BYTES      = BUS_W / 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             in_valid;
  logic [7:0]       in_data;
  logic             in_ready;
  logic [BUS_W-1:0] cfg_data;
  logic             cfg_valid;
  logic             cfg_ready;
  logic             cfg_ncfg;
  logic             cfg_nstatus;
  logic             cfg_conf_done;
  logic             src_rewind;
  logic             done;
  logic             err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [BUS_W-1:0] exp_q [$];
  logic [7:0]       acc [BYTES];
  int               acc_n = 0;

  int   rdy_mode  = 1;
  logic hold_low  = 1'b0;
  logic [2:0] nst_pipe = 3'b111;
  logic saw_low    = 1'b0;
  logic saw_rewind = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_host #(.BUS_W(BUS_W), .SKID_DEPTH(DEPTH)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .cfg_data      (cfg_data),
    .cfg_valid     (cfg_valid),
    .cfg_ready     (cfg_ready),
    .cfg_ncfg      (cfg_ncfg),
    .cfg_nstatus   (cfg_nstatus),
    .cfg_conf_done (cfg_conf_done),
    .src_rewind    (src_rewind),
    .done          (done),
    .err           (err)
  );

  assign cfg_nstatus = nst_pipe[2] & ~hold_low;

  // target model and ready pattern, driven between edges
  initial begin
    forever begin
      @(negedge clk);
      nst_pipe <= {nst_pipe[1:0], cfg_ncfg};
      case (rdy_mode)
        0:       cfg_ready <= 1'b0;
        2:       cfg_ready <= (cyc % 3) != 0;
        default: cfg_ready <= 1'b1;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!cfg_ncfg) saw_low <= 1'b1;
      if (src_rewind && !cfg_ncfg) saw_rewind <= 1'b1;
      if (cfg_valid) begin
        checks = checks + 1;
        if (exp_q.size() == 0) begin
          fails = fails + 1;
          $display("FAIL R4 unexpected word: actual %0h expected none", cfg_data);
        end else begin
          logic [BUS_W-1:0] w;
          w = exp_q.pop_front();
          if (cfg_data !== w) begin
            fails = fails + 1;
            $display("FAIL R3/R5 word: actual %0h expected %0h", cfg_data, w);
          end
        end
      end
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic note_byte(input logic [7:0] b);
    acc[acc_n] = b;
    acc_n = acc_n + 1;
    if (acc_n == BYTES) begin
      logic [BUS_W-1:0] w;
      for (int i = 0; i < BYTES; i++) w[i*8 +: 8] = acc[i];
      exp_q.push_back(w);
      acc_n = 0;
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = byte_of(seed + i);
      while (!in_ready) @(negedge clk);
      note_byte(byte_of(seed + i));
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stream(input string tag);
    int n = 0;
    while (!in_ready && n < 300) begin
      @(negedge clk);
      n++;
    end
    check_eq(tag, {31'b0, in_ready}, 32'd1);
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    wait_cycles(2);
    check_eq(tag, exp_q.size(), 0);
  endtask

  initial begin
    int taken;
    rst_n = 1'b0;
    start = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    cfg_conf_done = 1'b0;
    cfg_ready = 1'b0;
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(2);

    // R1 reset state
    check_eq("R1 ncfg", {31'b0, cfg_ncfg}, 32'd1);
    check_eq("R1 valid", {31'b0, cfg_valid}, 32'd0);
    check_eq("R1 in_ready", {31'b0, in_ready}, 32'd0);
    check_eq("R1 rewind", {31'b0, src_rewind}, 32'd0);
    check_eq("R1 status", {30'b0, done, err}, 32'd0);

    // R2 start blocked while status is held low
    hold_low = 1'b1;
    wait_cycles(4);
    pulse_start();
    wait_cycles(15);
    check_eq("R2 ncfg held while status low", {31'b0, cfg_ncfg}, 32'd1);
    check_eq("R2 no pulse yet", {31'b0, saw_low}, 32'd0);
    check_eq("R2 not streaming", {31'b0, in_ready}, 32'd0);
    hold_low = 1'b0;
    wait_stream("R2 streaming after handshake");
    check_eq("R2 request pulsed", {31'b0, saw_low}, 32'd1);
    check_eq("R2 ncfg high while streaming", {31'b0, cfg_ncfg}, 32'd1);

    // R3 lane order with ready steady
    send_bytes(16, 0);
    wait_drain("R3 words drained");

    // R5 ready toggling
    rdy_mode = 2;
    send_bytes(24, 100);
    wait_drain("R5 words drained under toggling ready");
    rdy_mode = 1;

    // R6 back-pressure fills the queue
    rdy_mode = 0;
    wait_cycles(5);
    taken = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = byte_of(500 + taken);
      if (in_ready) begin
        note_byte(byte_of(500 + taken));
        taken++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R6 bytes accepted while blocked", taken, DEPTH * BYTES);
    check_eq("R6 in_ready low when full", {31'b0, in_ready}, 32'd0);
    check_eq("R4 no valid without ready", {31'b0, cfg_valid}, 32'd0);
    rdy_mode = 1;
    wait_drain("R6 queue drained after release");

    // R7 completion
    cfg_conf_done = 1'b1;
    wait_cycles(6);
    check_eq("R7 done", {31'b0, done}, 32'd1);
    check_eq("R7 in_ready low", {31'b0, in_ready}, 32'd0);
    check_eq("R7 valid low", {31'b0, cfg_valid}, 32'd0);
    check_eq("R7 ncfg high", {31'b0, cfg_ncfg}, 32'd1);
    cfg_conf_done = 1'b0;
    wait_cycles(4);

    // R9 start clears done
    pulse_start();
    wait_cycles(1);
    check_eq("R9 done cleared", {31'b0, done}, 32'd0);
    wait_stream("R9 second attempt streams");

    // R8 status error mid-word
    send_bytes(6, 200);
    wait_drain("R8 full word sent before error");
    hold_low = 1'b1;
    wait_cycles(8);
    check_eq("R8 err", {31'b0, err}, 32'd1);
    check_eq("R8 ncfg high", {31'b0, cfg_ncfg}, 32'd1);
    check_eq("R8 in_ready low", {31'b0, in_ready}, 32'd0);
    check_eq("R8 valid low", {31'b0, cfg_valid}, 32'd0);
    hold_low = 1'b0;
    acc_n = 0;
    wait_cycles(6);

    // R9 restart after error
    saw_rewind = 1'b0;
    pulse_start();
    wait_cycles(1);
    check_eq("R9 err cleared", {31'b0, err}, 32'd0);
    wait_stream("R9 restart streams");
    check_eq("R9 rewind during request", {31'b0, saw_rewind}, 32'd1);
    send_bytes(8, 300);
    wait_drain("R9 fresh words after restart");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule